// File: doc/BRIEF.md
# Local Interrupt Register Window

This block is the software-visible face of a per-core local interrupt controller. It claims one 4 KB page of the physical address map and answers loads and stores that fall inside it. The page starts at a base that can be reprogrammed and comes out of reset at 0xFEE00000. Inside the page it keeps the configuration words: identity, task priority, logical destination, destination format, spurious vector, error status, the two halves of the command word, six local vector entries, and the timer initial count, current count and divide setting. The arbitration and processor priority values come in from a separate priority tracker and are shown read-only. The same holds for the 256-bit in-service, trigger-mode and request vectors, which appear as eight 32-bit words each.

Requests arrive on a simple one-cycle bus that carries an address, a byte length and write data. Every request that hits the page is answered exactly one clock later with a valid strobe, an error flag and read data. Side effects appear in that same response cycle. A store to the end-of-interrupt offset sends a one-cycle pulse to the priority tracker. A store to the low command word sends a one-cycle pulse that carries the full 64-bit command. A global enable bit, held with the base, turns every access into an error while it is clear.

Top module: `lrw_top`

## Requirements
- R1: After reset the window reads back version 0x80050010, spurious vector 0x000000FF, destination format 0xFFFFFFFF and 0x00010000 in each of the six local vector entries (offsets 0x320 to 0x370). Every other writable word reads 0. The base is 0xFEE00000 with the enable set, and no response, pulse or command is active.
- R2: A request whose address bits [31:12] equal the current base page gets rsp_valid exactly one cycle later. Any other request gets no response. Pulsing base_wr loads base_page and base_en.
- R3: Registers sit on 16-byte boundaries, and the two low address bits play no part in picking one. A dword whose offset has bit 2 or bit 3 set, or an offset that holds no register, reads 0 without error.
- R4: A 1-byte read returns the byte at lane addr[1:0] in rsp_rdata[7:0] with the upper bits 0. A 4-byte read returns the whole word. Any other read length gives an error.
- R5: A write whose length is not 4 gives an error and changes no register. It raises neither the end-of-interrupt pulse nor the send pulse.
- R6: Writes to the read-only words (version 0x030, arbitration 0x090, processor priority 0x0A0, remote read 0x0C0, and the vector words 0x100 to 0x270) and to unused offsets complete without error and change nothing.
- R7: The word at 0x100+16k reads in-service bits [32k+31:32k]. The word at 0x180+16k reads trigger bits and 0x200+16k reads request bits, for k from 0 to 7. Offsets 0x090 and 0x0A0 read the 8-bit arbitration and processor priority inputs, zero-extended.
- R8: The writable words (0x020, 0x080, 0x0D0, 0x0E0, 0x0F0, 0x280, 0x300, 0x310, 0x320 to 0x370, 0x380, 0x390, 0x3E0) store a 4-byte write and read it back unchanged.
- R9: A 4-byte write to 0x300 raises cmd_send for one cycle, in the response cycle. cmd_word then holds {high word at 0x310, new low word}. A write to 0x310 only stores the value.
- R10: A 4-byte write to 0x0B0 raises eoi_pulse for one cycle, in the response cycle. Reading 0x0B0 returns 0.
- R11: While the enable is clear, every read and write inside the page returns an error with rsp_rdata 0 and changes no register. Every error response carries rsp_rdata 0.
- R12: Writing the timer initial count at 0x380 also loads the same value into the current count at 0x390.
- R13: tpr_o always shows bits [7:0] of the task priority word at 0x080.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Loads base page and enable |
| base_page | input | 20 | New address bits [31:12] of the window |
| base_en | input | 1 | New global enable |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | 32 | Byte address |
| req_len | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Store data |
| irr_vec | input | 256 | Request bits from the priority tracker |
| isr_vec | input | 256 | In-service bits from the priority tracker |
| trig_vec | input | 256 | Trigger-mode bits from the priority tracker |
| arb_prio | input | 8 | Arbitration priority value |
| proc_prio | input | 8 | Processor priority value |
| rsp_valid | output | 1 | Response strobe, one cycle after a hit |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Load data |
| eoi_pulse | output | 1 | End-of-interrupt pulse |
| cmd_send | output | 1 | Command send pulse |
| cmd_word | output | 64 | Full command, high word above low word |
| tpr_o | output | 8 | Current task priority |

## Verification
The checks assume that the priority-tracker inputs stay stable while a read is in flight. They also assume the base is never reprogrammed in the same cycle as an access, so each request is judged against one base and one enable. The stimulus makes only one request at a time and holds the vector and priority inputs at fixed, arithmetically generated patterns. It changes the base only between accesses. It sweeps every dword of the page for reads and for writes, and then adds focused runs for byte lanes, bad lengths, a moved window and the disabled state.

// File: rtl/lrw_pkg.sv
package lrw_pkg;

  typedef enum logic [4:0] {
    RK_NONE, RK_ID, RK_VER, RK_TPR, RK_APR, RK_PPR, RK_EOI, RK_RRD,
    RK_LDR, RK_DFR, RK_SVR, RK_ISR, RK_TMR, RK_IRR, RK_ESR,
    RK_CMDLO, RK_CMDHI, RK_LVT, RK_TINIT, RK_TCUR, RK_TDIV
  } rkind_e;

  typedef struct packed {
    rkind_e     kind;
    logic [2:0] idx;
  } rsel_t;

  localparam logic [31:0] VERSION_WORD = 32'h8005_0010;
  localparam logic [31:0] LVT_RESET    = 32'h0001_0000;
  localparam logic [31:0] SVR_RESET    = 32'h0000_00FF;
  localparam logic [31:0] DFR_RESET    = 32'hFFFF_FFFF;

  // Page offset (low two bits already cleared) to register kind.
  function automatic rsel_t lrw_decode(input logic [11:0] off);
    rsel_t s;
    s.kind = RK_NONE;
    s.idx  = off[6:4];
    if (off[3:2] == 2'b00) begin
      case (off[11:4]) inside
        8'h02: s.kind = RK_ID;
        8'h03: s.kind = RK_VER;
        8'h08: s.kind = RK_TPR;
        8'h09: s.kind = RK_APR;
        8'h0A: s.kind = RK_PPR;
        8'h0B: s.kind = RK_EOI;
        8'h0C: s.kind = RK_RRD;
        8'h0D: s.kind = RK_LDR;
        8'h0E: s.kind = RK_DFR;
        8'h0F: s.kind = RK_SVR;
        [8'h10:8'h17]: s.kind = RK_ISR;
        [8'h18:8'h1F]: s.kind = RK_TMR;
        [8'h20:8'h27]: s.kind = RK_IRR;
        8'h28: s.kind = RK_ESR;
        8'h30: s.kind = RK_CMDLO;
        8'h31: s.kind = RK_CMDHI;
        [8'h32:8'h37]: begin
          s.kind = RK_LVT;
          s.idx  = off[6:4] - 3'd2;
        end
        8'h38: s.kind = RK_TINIT;
        8'h39: s.kind = RK_TCUR;
        8'h3E: s.kind = RK_TDIV;
        default: s.kind = RK_NONE;
      endcase
    end
    return s;
  endfunction

  // Byte-lane extraction for a load.
  function automatic logic [31:0] lane_pick(input logic [31:0] word,
                                            input logic [1:0]  lane,
                                            input logic [2:0]  len);
    if (len == 3'd1) return {24'd0, word[8*lane +: 8]};
    return word;
  endfunction

endpackage

// File: rtl/lrw_base.sv
module lrw_base #(
  parameter logic [31:0] BASE_RESET = 32'hFEE0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_wr,
  input  logic [19:0] base_page,
  input  logic        base_en,
  output logic [19:0] page_q,
  output logic        en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= BASE_RESET[31:12];
      en_q   <= 1'b1;
    end else if (base_wr) begin
      page_q <= base_page;
      en_q   <= base_en;
    end
  end
endmodule

// File: rtl/lrw_regs.sv
module lrw_regs
  import lrw_pkg::*;
#(
  parameter int          NUM_LVT  = 6,
  parameter logic [31:0] ID_RESET = 32'd0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  rsel_t                     sel,
  input  logic [31:0]               wdata,
  output logic [31:0]               id_q,
  output logic [31:0]               tpr_q,
  output logic [31:0]               ldr_q,
  output logic [31:0]               dfr_q,
  output logic [31:0]               svr_q,
  output logic [31:0]               esr_q,
  output logic [31:0]               cmdlo_q,
  output logic [31:0]               cmdhi_q,
  output logic [NUM_LVT-1:0][31:0]  lvt_q,
  output logic [31:0]               tinit_q,
  output logic [31:0]               tcur_q,
  output logic [31:0]               tdiv_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q    <= ID_RESET;
      tpr_q   <= '0;
      ldr_q   <= '0;
      dfr_q   <= DFR_RESET;
      svr_q   <= SVR_RESET;
      esr_q   <= '0;
      cmdlo_q <= '0;
      cmdhi_q <= '0;
      tinit_q <= '0;
      tcur_q  <= '0;
      tdiv_q  <= '0;
    end else if (wr_en) begin
      case (sel.kind)
        RK_ID:    id_q    <= wdata;
        RK_TPR:   tpr_q   <= wdata;
        RK_LDR:   ldr_q   <= wdata;
        RK_DFR:   dfr_q   <= wdata;
        RK_SVR:   svr_q   <= wdata;
        RK_ESR:   esr_q   <= wdata;
        RK_CMDLO: cmdlo_q <= wdata;
        RK_CMDHI: cmdhi_q <= wdata;
        RK_TINIT: begin
          tinit_q <= wdata;
          tcur_q  <= wdata;
        end
        RK_TCUR:  tcur_q  <= wdata;
        RK_TDIV:  tdiv_q  <= wdata;
        default:  ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_LVT; g++) begin : g_lvt
    always_ff @(posedge clk) begin
      if (!rst_n)
        lvt_q[g] <= LVT_RESET;
      else if (wr_en && sel.kind == RK_LVT && sel.idx == 3'(g))
        lvt_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/lrw_rdmux.sv
module lrw_rdmux
  import lrw_pkg::*;
#(
  parameter int NUM_LVT   = 6,
  parameter int VEC_WORDS = 8,
  localparam int VEC_BITS = VEC_WORDS * 32
) (
  input  rsel_t                     sel,
  input  logic [31:0]               id_q,
  input  logic [31:0]               tpr_q,
  input  logic [31:0]               ldr_q,
  input  logic [31:0]               dfr_q,
  input  logic [31:0]               svr_q,
  input  logic [31:0]               esr_q,
  input  logic [31:0]               cmdlo_q,
  input  logic [31:0]               cmdhi_q,
  input  logic [NUM_LVT-1:0][31:0]  lvt_q,
  input  logic [31:0]               tinit_q,
  input  logic [31:0]               tcur_q,
  input  logic [31:0]               tdiv_q,
  input  logic [VEC_BITS-1:0]       irr_vec,
  input  logic [VEC_BITS-1:0]       isr_vec,
  input  logic [VEC_BITS-1:0]       trig_vec,
  input  logic [7:0]                arb_prio,
  input  logic [7:0]                proc_prio,
  output logic [31:0]               word
);
  logic idx_in_vec, idx_in_lvt;
  assign idx_in_vec = int'(sel.idx) < VEC_WORDS;
  assign idx_in_lvt = int'(sel.idx) < NUM_LVT;

  always_comb begin
    word = '0;
    case (sel.kind)
      RK_ID:    word = id_q;
      RK_VER:   word = VERSION_WORD;
      RK_TPR:   word = tpr_q;
      RK_APR:   word = {24'd0, arb_prio};
      RK_PPR:   word = {24'd0, proc_prio};
      RK_LDR:   word = ldr_q;
      RK_DFR:   word = dfr_q;
      RK_SVR:   word = svr_q;
      RK_ISR:   if (idx_in_vec) word = isr_vec[32*sel.idx +: 32];
      RK_TMR:   if (idx_in_vec) word = trig_vec[32*sel.idx +: 32];
      RK_IRR:   if (idx_in_vec) word = irr_vec[32*sel.idx +: 32];
      RK_ESR:   word = esr_q;
      RK_CMDLO: word = cmdlo_q;
      RK_CMDHI: word = cmdhi_q;
      RK_LVT:   if (idx_in_lvt) word = lvt_q[sel.idx];
      RK_TINIT: word = tinit_q;
      RK_TCUR:  word = tcur_q;
      RK_TDIV:  word = tdiv_q;
      default:  word = '0;
    endcase
  end
endmodule

// File: rtl/lrw_top.sv
module lrw_top
  import lrw_pkg::*;
#(
  parameter logic [31:0] BASE_RESET = 32'hFEE0_0000,
  parameter logic [31:0] ID_RESET   = 32'd0,
  parameter int          NUM_LVT    = 6,
  parameter int          VEC_WORDS  = 8,
  localparam int         VEC_BITS   = VEC_WORDS * 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                base_wr,
  input  logic [19:0]         base_page,
  input  logic                base_en,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [31:0]         req_addr,
  input  logic [2:0]          req_len,
  input  logic [31:0]         req_wdata,
  input  logic [VEC_BITS-1:0] irr_vec,
  input  logic [VEC_BITS-1:0] isr_vec,
  input  logic [VEC_BITS-1:0] trig_vec,
  input  logic [7:0]          arb_prio,
  input  logic [7:0]          proc_prio,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [31:0]         rsp_rdata,
  output logic                eoi_pulse,
  output logic                cmd_send,
  output logic [63:0]         cmd_word,
  output logic [7:0]          tpr_o
);
  logic [19:0] page_q;
  logic        en_q;

  lrw_base #(.BASE_RESET(BASE_RESET)) u_base (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_page(base_page),
    .base_en(base_en), .page_q(page_q), .en_q(en_q)
  );

  // Named internal events used by the checker.
  logic  win_hit, acc_err, wr_go, rd_go;
  rsel_t sel;
  assign sel     = lrw_decode({req_addr[11:2], 2'b00});
  assign win_hit = req_valid && (req_addr[31:12] == page_q);
  assign acc_err = !en_q || (req_write ? (req_len != 3'd4)
                                       : !(req_len == 3'd1 || req_len == 3'd4));
  assign wr_go   = win_hit && req_write && !acc_err;
  assign rd_go   = win_hit && !req_write && !acc_err;

  logic [31:0] id_q, tpr_q, ldr_q, dfr_q, svr_q, esr_q;
  logic [31:0] cmdlo_q, cmdhi_q, tinit_q, tcur_q, tdiv_q;
  logic [NUM_LVT-1:0][31:0] lvt_q;
  logic [31:0] rd_word;

  lrw_regs #(.NUM_LVT(NUM_LVT), .ID_RESET(ID_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .sel(sel), .wdata(req_wdata),
    .id_q(id_q), .tpr_q(tpr_q), .ldr_q(ldr_q), .dfr_q(dfr_q), .svr_q(svr_q),
    .esr_q(esr_q), .cmdlo_q(cmdlo_q), .cmdhi_q(cmdhi_q), .lvt_q(lvt_q),
    .tinit_q(tinit_q), .tcur_q(tcur_q), .tdiv_q(tdiv_q)
  );

  lrw_rdmux #(.NUM_LVT(NUM_LVT), .VEC_WORDS(VEC_WORDS)) u_rdmux (
    .sel(sel), .id_q(id_q), .tpr_q(tpr_q), .ldr_q(ldr_q), .dfr_q(dfr_q),
    .svr_q(svr_q), .esr_q(esr_q), .cmdlo_q(cmdlo_q), .cmdhi_q(cmdhi_q),
    .lvt_q(lvt_q), .tinit_q(tinit_q), .tcur_q(tcur_q), .tdiv_q(tdiv_q),
    .irr_vec(irr_vec), .isr_vec(isr_vec), .trig_vec(trig_vec),
    .arb_prio(arb_prio), .proc_prio(proc_prio), .word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      eoi_pulse <= 1'b0;
      cmd_send  <= 1'b0;
    end else begin
      rsp_valid <= win_hit;
      rsp_err   <= win_hit && acc_err;
      rsp_rdata <= rd_go ? lane_pick(rd_word, req_addr[1:0], req_len) : '0;
      eoi_pulse <= wr_go && (sel.kind == RK_EOI);
      cmd_send  <= wr_go && (sel.kind == RK_CMDLO);
    end
  end

  assign cmd_word = {cmdhi_q, cmdlo_q};
  assign tpr_o    = tpr_q[7:0];
endmodule

// File: rtl/lrw_chk.sv
module lrw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_write,
  input logic [31:0] req_addr,
  input logic [2:0]  req_len,
  input logic [31:0] req_wdata,
  input logic        win_hit,
  input logic        en_q,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        eoi_pulse,
  input logic        cmd_send,
  input logic [63:0] cmd_word
);
  AST_HIT_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |=> rsp_valid); // R2
  AST_MISS_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |=> !rsp_valid); // R2
  AST_BYTE_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && !req_write && req_len == 3'd1) |=> (rsp_rdata[31:8] == 24'd0)); // R4
  AST_SHORT_WRITE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && req_write && req_len != 3'd4) |=> (rsp_err && !cmd_send && !eoi_pulse)); // R5
  AST_SEND_CARRIES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_send |-> (rsp_valid && !rsp_err && cmd_word[31:0] == $past(req_wdata))); // R9
  AST_EOI_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> ($past(req_write) && $past(req_addr[11:2]) == 10'h02C && rsp_valid)); // R10
  AST_DISABLED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && !en_q) |=> (rsp_err && !cmd_send && !eoi_pulse)); // R11
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'd0)); // R11
endmodule

bind lrw_top lrw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_write(req_write), .req_addr(req_addr),
  .req_len(req_len), .req_wdata(req_wdata), .win_hit(win_hit), .en_q(en_q),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .eoi_pulse(eoi_pulse), .cmd_send(cmd_send), .cmd_word(cmd_word)
);

// File: tb/tb_lrw_top.sv
`timescale 1ns/1ps
module tb_lrw_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         base_wr = 1'b0;
  logic [19:0]  base_page = '0;
  logic         base_en = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic [2:0]   req_len = 3'd4;
  logic [255:0] irr_vec, isr_vec, trig_vec;
  logic [7:0]   arb_prio = 8'h3C, proc_prio = 8'hA7;
  logic         rsp_valid, rsp_err, eoi_pulse, cmd_send;
  logic [31:0]  rsp_rdata;
  logic [63:0]  cmd_word;
  logic [7:0]   tpr_o;

  always #2.5 clk = ~clk;

  lrw_top dut (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_page(base_page),
    .base_en(base_en), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .irr_vec(irr_vec), .isr_vec(isr_vec), .trig_vec(trig_vec),
    .arb_prio(arb_prio), .proc_prio(proc_prio), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .eoi_pulse(eoi_pulse),
    .cmd_send(cmd_send), .cmd_word(cmd_word), .tpr_o(tpr_o)
  );

  int n_checks = 0, n_fail = 0;
  logic [31:0] model [0:1023];
  logic [31:0] page_base = 32'hFEE0_0000;

  function automatic logic [31:0] vword(input int seed, input int k);
    return (32'(seed) << 24) ^ (32'(k) * 32'h0101_0137) ^ 32'h005A_C3E1;
  endfunction

  function automatic bit writable(input int off);
    if (off >= 12'h320 && off <= 12'h370 && off[3:0] == 4'h0) return 1'b1;
    return off == 12'h020 || off == 12'h080 || off == 12'h0D0 || off == 12'h0E0 ||
           off == 12'h0F0 || off == 12'h280 || off == 12'h300 || off == 12'h310 ||
           off == 12'h380 || off == 12'h390 || off == 12'h3E0;
  endfunction

  function automatic logic [31:0] expect_word(input int off);
    if (writable(off)) return model[off >> 2];
    if (off == 12'h030) return 32'h8005_0010;
    if (off == 12'h090) return {24'd0, arb_prio};
    if (off == 12'h0A0) return {24'd0, proc_prio};
    if (off[3:0] == 4'h0 && off >= 12'h100 && off < 12'h180) return vword(1, (off - 12'h100) >> 4);
    if (off[3:0] == 4'h0 && off >= 12'h180 && off < 12'h200) return vword(2, (off - 12'h180) >> 4);
    if (off[3:0] == 4'h0 && off >= 12'h200 && off < 12'h280) return vword(3, (off - 12'h200) >> 4);
    return 32'd0;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [31:0] a, input logic [2:0] ln,
                     input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = ln; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic set_base(input logic [19:0] pg, input bit en);
    @(negedge clk);
    base_wr = 1'b1; base_page = pg; base_en = en;
    @(negedge clk);
    base_wr = 1'b0;
    page_base = {pg, 12'h000};
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      isr_vec[32*k +: 32]  = vword(1, k);
      trig_vec[32*k +: 32] = vword(2, k);
      irr_vec[32*k +: 32]  = vword(3, k);
    end
    for (int i = 0; i < 1024; i++) model[i] = 32'd0;
    model[12'h0E0 >> 2] = 32'hFFFF_FFFF;
    model[12'h0F0 >> 2] = 32'h0000_00FF;
    for (int i = 12'h320; i <= 12'h370; i += 16) model[i >> 2] = 32'h0001_0000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 idle outputs after reset
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 cmd_send", 64'(cmd_send), 64'd0);
    check("R1 eoi_pulse", 64'(eoi_pulse), 64'd0);
    check("R1 tpr_o", 64'(tpr_o), 64'd0);

    // R1 R3 R7: read every dword of the page after reset
    for (int dw = 0; dw < 1024; dw++) begin
      acc(1'b0, page_base + 32'(dw * 4), 3'd4, 32'd0);
      check("R1 reset read valid", 64'({rsp_valid, rsp_err}), 64'b10);
      check("R1 reset read data", 64'(rsp_rdata), 64'(expect_word(dw * 4)));
    end

    // R4: byte lanes of version and of an in-service word
    for (int ln = 0; ln < 4; ln++) begin
      logic [31:0] v = 32'h8005_0010;
      logic [31:0] w = vword(1, 3);
      acc(1'b0, page_base + 32'h030 + 32'(ln), 3'd1, 32'd0);
      check("R4 byte lane version", 64'(rsp_rdata), 64'({24'd0, v[8*ln +: 8]}));
      acc(1'b0, page_base + 32'h130 + 32'(ln), 3'd1, 32'd0);
      check("R4 byte lane isr", 64'(rsp_rdata), 64'({24'd0, w[8*ln +: 8]}));
    end
    // R3: low address bits ignored on a full-word read
    acc(1'b0, page_base + 32'h033, 3'd4, 32'd0);
    check("R3 low bits ignored", 64'(rsp_rdata), 64'(32'h8005_0010));
    // R4: two-byte read rejected
    acc(1'b0, page_base + 32'h030, 3'd2, 32'd0);
    check("R4 len2 read err", 64'({rsp_valid, rsp_err}), 64'b11);
    check("R4 len2 read data", 64'(rsp_rdata), 64'd0);

    // R6 R9 R10: write every dword, watch the side-effect pulses
    for (int dw = 0; dw < 1024; dw++) begin
      logic [31:0] p = 32'hC0DE_0000 ^ (32'(dw) * 32'h9E37_79B1);
      acc(1'b1, page_base + 32'(dw * 4), 3'd4, p);
      check("R6 write no err", 64'({rsp_valid, rsp_err}), 64'b10);
      check("R10 eoi only at 0x0B0", 64'(eoi_pulse), 64'(dw * 4 == 12'h0B0));
      check("R9 send only at 0x300", 64'(cmd_send), 64'(dw * 4 == 12'h300));
      if (writable(dw * 4)) model[dw] = p;
      if (dw * 4 == 12'h380) model[12'h390 >> 2] = p;
    end
    // R8 R6: read every dword back
    for (int dw = 0; dw < 1024; dw++) begin
      acc(1'b0, page_base + 32'(dw * 4), 3'd4, 32'd0);
      check("R8 readback", 64'(rsp_rdata), 64'(expect_word(dw * 4)));
    end

    // R9: high word stores only, low word sends full command
    acc(1'b1, page_base + 32'h310, 3'd4, 32'h1234_5678);
    check("R9 hi no send", 64'(cmd_send), 64'd0);
    acc(1'b1, page_base + 32'h300, 3'd4, 32'hAABB_CCDD);
    check("R9 lo send", 64'(cmd_send), 64'd1);
    check("R9 cmd word", cmd_word, 64'h1234_5678_AABB_CCDD);
    @(negedge clk);
    check("R9 send one cycle", 64'(cmd_send), 64'd0);
    model[12'h300 >> 2] = 32'hAABB_CCDD;
    model[12'h310 >> 2] = 32'h1234_5678;

    // R12: initial count loads current count
    acc(1'b1, page_base + 32'h380, 3'd4, 32'd777);
    acc(1'b0, page_base + 32'h390, 3'd4, 32'd0);
    check("R12 current count", 64'(rsp_rdata), 64'd777);

    // R13: task priority output
    acc(1'b1, page_base + 32'h080, 3'd4, 32'h0000_01C7);
    check("R13 tpr_o", 64'(tpr_o), 64'hC7);
    model[12'h080 >> 2] = 32'h0000_01C7;

    // R5: sub-dword writes rejected, register unchanged
    acc(1'b1, page_base + 32'h0F0, 3'd1, 32'h11);
    check("R5 len1 write err", 64'({rsp_valid, rsp_err}), 64'b11);
    acc(1'b1, page_base + 32'h300, 3'd2, 32'h2222);
    check("R5 len2 no send", 64'({rsp_err, cmd_send}), 64'b10);
    acc(1'b0, page_base + 32'h0F0, 3'd4, 32'd0);
    check("R5 svr unchanged", 64'(rsp_rdata), 64'(model[12'h0F0 >> 2]));

    // R2: outside the page, then a moved page
    acc(1'b0, page_base + 32'h1030, 3'd4, 32'd0);
    check("R2 miss no rsp", 64'(rsp_valid), 64'd0);
    set_base(20'h12345, 1'b1);
    acc(1'b0, 32'h1234_5030, 3'd4, 32'd0);
    check("R2 new base hit", 64'({rsp_valid, rsp_rdata}), {31'd0, 1'b1, 32'h8005_0010});
    acc(1'b0, 32'hFEE0_0030, 3'd4, 32'd0);
    check("R2 old base miss", 64'(rsp_valid), 64'd0);

    // R11: disabled window
    set_base(20'h12345, 1'b0);
    acc(1'b0, page_base + 32'h030, 3'd4, 32'd0);
    check("R11 disabled read", 64'({rsp_valid, rsp_err, rsp_rdata}), {30'd0, 2'b11, 32'd0});
    acc(1'b1, page_base + 32'h080, 3'd4, 32'h55);
    check("R11 disabled write err", 64'({rsp_valid, rsp_err}), 64'b11);
    check("R11 tpr kept", 64'(tpr_o), 64'hC7);
    set_base(20'h12345, 1'b1);
    acc(1'b0, page_base + 32'h080, 3'd4, 32'd0);
    check("R11 tpr readback", 64'(rsp_rdata), 64'(32'h0000_01C7));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule